// File: doc/BRIEF.md
# DMA Hardware Trigger Conditioner

This block sits in front of one DMA channel's transfer engine and decides when the engine may begin its next piece of work. One of several asynchronous hardware event lines is picked by an index. The chosen line is brought into the clock domain and watched for a rising or a falling edge; a polarity setting may also mask it entirely. Each qualifying edge is a "hit". A hit is held as a single credit until the engine starts the next unit of work.

The size of that unit is programmable over four levels of the transfer hierarchy: one block, one repeated block, one linked-list item, or one single/burst transfer. The engine raises `eng_start` when it takes the permission and pulses one bit of `eng_done` each time it finishes a unit at some level. Only the bit for the configured level closes the unit. A hit that arrives while a credit is already waiting is lost and is flagged by a sticky overrun output.

Configuration inputs are expected to change only while the event lines are quiet, because a change of index or polarity can itself look like an edge.

Top module: `dma_trig_gate`

## Requirements
- R1: A change on the selected event input is seen at `go` on the third rising clock edge after it, and not on the second.
- R2: With `cfg_pol` = 1 only low-to-high transitions count as hits. With `cfg_pol` = 2 only high-to-low transitions count. The opposite transition is ignored in both cases.
- R3: With `cfg_pol` = 0 or 3 the trigger is masked. `go` is held low, and edges arriving while masked are not recorded. A credit already held is kept and shows on `go` again once a live polarity is restored.
- R4: Only the input whose index equals `cfg_sel` can produce a hit. An index of `NUM_EVT` (46) or above selects no input.
- R5: One hit permits exactly one unit. A cycle where `go` and `eng_start` are both high consumes the credit, and `go` stays low until that unit ends and a further hit exists.
- R6: A unit ends only on a pulse of `eng_done[cfg_mode]`, with mode 0 = block, 1 = repeated block, 2 = linked-list item and 3 = single/burst transfer. The other bits of `eng_done` have no effect.
- R7: A hit that arrives during a unit is held. `go` rises in the cycle after the matching `eng_done` pulse.
- R8: A hit while a credit is held and is not consumed in the same cycle sets `ovr`. The flag stays high until cleared. A hit in the same cycle as a consuming start does not set it.
- R9: `ovr_clr` clears `ovr` on the next edge and takes priority over a simultaneous set.
- R10: After synchronous reset (`rst_n` low at a clock edge) `go` and `ovr` are low.
- R11: `eng_start` while `go` is low has no effect on the block's state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_in | input | NUM_EVT | Asynchronous hardware event lines |
| cfg_sel | input | $clog2(NUM_EVT) | Index of the event line to watch |
| cfg_pol | input | 2 | 0 masked, 1 rising, 2 falling, 3 masked |
| cfg_mode | input | 2 | Unit released per hit: 0 block, 1 repeated block, 2 list item, 3 single/burst |
| eng_start | input | 1 | Engine starts a unit (taken only while `go` is high) |
| eng_done | input | 4 | Engine finished a unit; bit index is the hierarchy level |
| ovr_clr | input | 1 | Clears the overrun flag |
| go | output | 1 | Permission for the engine to start a unit |
| ovr | output | 1 | Sticky overrun: a hit was lost |

## Verification
The hardest case to reach is a hit that lands in exactly the cycle where the engine consumes the previous credit. It must neither raise the overrun flag nor be lost. The bench reaches it by counting the synchronizer and edge-detector delay from the moment it drives the event pin. It raises `eng_start` in the single cycle where the edge pulse is live, and then confirms that `go` returns right after the unit ends. A sweep over every valid selection index, with the mode rotating through all four levels, pairs each index with a decoy toggle on its neighbour and with wrong-level done pulses.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the trigger conditioner.
// Assumes: the 2-bit polarity and mode codes are fixed by software.
package trig_pkg;
    localparam int GRAN_N = 4;   // transfer hierarchy levels

    typedef enum logic [1:0] {
        POL_OFF     = 2'd0,
        POL_RISE    = 2'd1,
        POL_FALL    = 2'd2,
        POL_OFF_ALT = 2'd3
    } pol_e;

    typedef enum logic [1:0] {
        GR_BLOCK  = 2'd0,
        GR_RBLOCK = 2'd1,
        GR_ITEM   = 2'd2,
        GR_XFER   = 2'd3
    } gran_e;
endpackage

// File: rtl/trig_sync_bank.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bank of asynchronous event lines.
// Assumes: inputs are level signals held for at least STAGES+1 clocks.
module trig_sync_bank #(
    parameter int N      = 46,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first capture flop of each line
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // further resolution stages
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/trig_edge_sel.sv
`timescale 1ns/1ps
// Selects one synchronized event line and detects the programmed edge.
// Assumes: cfg changes only while lines are quiet; out-of-range index gives no hit.
module trig_edge_sel
    import trig_pkg::*;
#(
    parameter int N     = 46,
    parameter int SEL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     sync_in,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       pol,
    output logic             hit
);
    localparam int PAD = 2 ** SEL_W;

    logic [PAD-1:0] padded;
    logic           lvl;
    logic           prev_q;
    logic           rise;
    logic           fall;

    for (genvar i = 0; i < PAD; i++) begin : g_pad
        if (i < N) begin : g_real
            assign padded[i] = sync_in[i];
        end else begin : g_none
            assign padded[i] = 1'b0;
        end
    end

    assign lvl  = padded[sel];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    // remembers last cycle's selected level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // picks the edge that counts under the current polarity
    always_comb begin
        case (pol_e'(pol))
            POL_RISE: hit = rise;
            POL_FALL: hit = fall;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trig_credit.sv
`timescale 1ns/1ps
// Holds one trigger credit, tracks the running unit and flags lost hits.
// Assumes: eng_start is sampled only while go is high; done bits are pulses.
module trig_credit
    import trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              masked,
    input  logic [1:0]        mode,
    input  logic              eng_start,
    input  logic [GRAN_N-1:0] eng_done,
    input  logic              ovr_clr,
    output logic              go,
    output logic              ovr
);
    logic pend_q;
    logic busy_q;
    logic ovr_q;
    logic take;
    logic unit_end;
    logic lost;

    assign go       = pend_q & ~busy_q & ~masked;
    assign take     = go & eng_start;
    assign unit_end = eng_done[mode];
    assign lost     = hit & pend_q & ~take;
    assign ovr      = ovr_q;

    // credit: consumed by a start, refilled by a hit
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (take)   pend_q <= hit;
        else if (hit)    pend_q <= 1'b1;
    end

    // unit in progress, opened by a start and closed by the level's done
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (take)     busy_q <= 1'b1;
        else if (unit_end) busy_q <= 1'b0;
    end

    // sticky overrun, clear has priority
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr_q <= 1'b0;
        else if (ovr_clr) ovr_q <= 1'b0;
        else if (lost)    ovr_q <= 1'b1;
    end
endmodule

// File: rtl/dma_trig_gate.sv
`timescale 1ns/1ps
// Trigger conditioner for one DMA channel: synchronize, select, edge-detect,
// and meter engine work one unit per hit at a programmable hierarchy level.
// Assumes: configuration is static while event lines toggle.
module dma_trig_gate
    import trig_pkg::*;
#(
    parameter int NUM_EVT     = 46,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = $clog2(NUM_EVT)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [1:0]         cfg_pol,
    input  logic [1:0]         cfg_mode,
    input  logic               eng_start,
    input  logic [GRAN_N-1:0]  eng_done,
    input  logic               ovr_clr,
    output logic               go,
    output logic               ovr
);
    logic [NUM_EVT-1:0] evt_sync;
    logic               hit;
    logic               masked;

    assign masked = (cfg_pol == POL_OFF) || (cfg_pol == POL_OFF_ALT);

    trig_sync_bank #(.N(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (evt_in),
        .dout (evt_sync)
    );

    trig_edge_sel #(.N(NUM_EVT), .SEL_W(SEL_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_in(evt_sync),
        .sel    (cfg_sel),
        .pol    (cfg_pol),
        .hit    (hit)
    );

    trig_credit u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .masked   (masked),
        .mode     (cfg_mode),
        .eng_start(eng_start),
        .eng_done (eng_done),
        .ovr_clr  (ovr_clr),
        .go       (go),
        .ovr      (ovr)
    );
endmodule

// File: rtl/dma_trig_gate_chk.sv
`timescale 1ns/1ps
// Port-level temporal checks for the trigger conditioner.
module dma_trig_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_pol,
    input logic       eng_start,
    input logic       ovr_clr,
    input logic       go,
    input logic       ovr
);
    a_r3_mask_blocks_go: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pol == 2'd0 || cfg_pol == 2'd3) |-> !go);

    a_r5_start_drops_go: assert property (@(posedge clk) disable iff (!rst_n)
        (go && eng_start) |=> !go);

    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_clr |=> !ovr);
endmodule

bind dma_trig_gate dma_trig_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_pol  (cfg_pol),
    .eng_start(eng_start),
    .ovr_clr  (ovr_clr),
    .go       (go),
    .ovr      (ovr)
);

// File: tb/dma_trig_gate_tb.sv
`timescale 1ns/1ps
module dma_trig_gate_tb;
    localparam int NE = 46;
    localparam int SW = $clog2(NE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic [SW-1:0] cfg_sel = '0;
    logic [1:0]    cfg_pol = 2'd1;
    logic [1:0]    cfg_mode = 2'd0;
    logic          eng_start = 1'b0;
    logic [3:0]    eng_done = 4'd0;
    logic          ovr_clr = 1'b0;
    logic          go;
    logic          ovr;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    dma_trig_gate u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_sel(cfg_sel),
        .cfg_pol(cfg_pol), .cfg_mode(cfg_mode), .eng_start(eng_start),
        .eng_done(eng_done), .ovr_clr(ovr_clr), .go(go), .ovr(ovr)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_pulse();
        eng_start = 1'b1; tick(1); eng_start = 1'b0;
    endtask

    task automatic done_pulse(logic [3:0] b);
        eng_done = b; tick(1); eng_done = 4'd0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        chk("R10 go after reset", go, 1'b0);
        chk("R10 ovr after reset", ovr, 1'b0);
        rst_n = 1'b1;
        tick(2);

        // sweep every valid index, rotating hierarchy level
        for (int s = 0; s < NE; s++) begin
            int other;
            logic [3:0] mine;
            other = (s + 1) % NE;
            cfg_sel = SW'(s); cfg_mode = 2'(s % 4); cfg_pol = 2'd1;
            mine = 4'(1 << (s % 4));
            tick(1);
            evt_in[other] = 1'b1; tick(4);
            chk("R4 decoy line", go, 1'b0);
            evt_in[other] = 1'b0; tick(4);
            evt_in[s] = 1'b1; tick(2);
            chk("R1 not yet at edge 2", go, 1'b0);
            tick(1);
            chk("R2 rising hit at edge 3", go, 1'b1);
            start_pulse();
            chk("R5 credit consumed", go, 1'b0);
            evt_in[s] = 1'b0; tick(2);
            evt_in[s] = 1'b1; tick(3);
            chk("R7 hit held during unit", go, 1'b0);
            done_pulse(4'hF ^ mine); tick(1);
            chk("R6 other-level done ignored", go, 1'b0);
            done_pulse(mine);
            chk("R7 go after matching done", go, 1'b1);
            start_pulse();
            done_pulse(mine);
            chk("R5 one unit per hit", go, 1'b0);
            evt_in[s] = 1'b0; tick(4);
            chk("R2 falling ignored on rising", go, 1'b0);
            chk("R8 no overrun in sweep", ovr, 1'b0);
        end

        // falling polarity
        cfg_sel = 6'd5; cfg_mode = 2'd3; cfg_pol = 2'd2; tick(1);
        evt_in[5] = 1'b1; tick(4);
        chk("R2 rising ignored on falling", go, 1'b0);
        evt_in[5] = 1'b0; tick(3);
        chk("R2 falling hit", go, 1'b1);
        start_pulse(); done_pulse(4'b1000); tick(2);

        // masked polarity
        cfg_sel = 6'd9; cfg_mode = 2'd2; cfg_pol = 2'd0; tick(1);
        evt_in[9] = 1'b1; tick(4);
        chk("R3 masked go low", go, 1'b0);
        evt_in[9] = 1'b0; tick(4);
        cfg_pol = 2'd1; tick(2);
        chk("R3 masked edge not recorded", go, 1'b0);
        evt_in[9] = 1'b1; tick(3);
        chk("R3 live hit", go, 1'b1);
        cfg_pol = 2'd0; tick(1);
        chk("R3 mask forces go low", go, 1'b0);
        cfg_pol = 2'd3; tick(1);
        chk("R3 code 3 also masks", go, 1'b0);
        cfg_pol = 2'd1; tick(1);
        chk("R3 credit kept over mask", go, 1'b1);
        start_pulse(); done_pulse(4'b0100);
        evt_in[9] = 1'b0; tick(4);

        // out-of-range index
        cfg_sel = 6'd47; tick(1);
        evt_in = '1; tick(4);
        chk("R4 index 47 selects none", go, 1'b0);
        evt_in = '0; tick(4);
        cfg_sel = 6'd46; tick(1);
        evt_in = '1; tick(4);
        chk("R4 index 46 selects none", go, 1'b0);
        evt_in = '0; tick(4);

        // start while go low is ignored
        cfg_sel = 6'd12; cfg_mode = 2'd0; tick(1);
        start_pulse(); tick(1);
        evt_in[12] = 1'b1; tick(3);
        chk("R11 stray start ignored", go, 1'b1);
        start_pulse(); done_pulse(4'b0001);
        evt_in[12] = 1'b0; tick(4);

        // overrun set, sticky, cleared
        cfg_sel = 6'd7; cfg_mode = 2'd1; tick(1);
        evt_in[7] = 1'b1; tick(3);
        evt_in[7] = 1'b0; tick(3);
        chk("R8 single hit no overrun", ovr, 1'b0);
        evt_in[7] = 1'b1; tick(3);
        chk("R8 second hit sets overrun", ovr, 1'b1);
        tick(5);
        chk("R8 overrun sticky", ovr, 1'b1);
        ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
        chk("R9 clear", ovr, 1'b0);
        chk("R9 credit survives clear", go, 1'b1);
        start_pulse(); done_pulse(4'b0010);
        evt_in[7] = 1'b0; tick(4);

        // hit in the very cycle the credit is consumed
        evt_in[7] = 1'b1; tick(3);
        evt_in[7] = 1'b0; tick(3);
        evt_in[7] = 1'b1; tick(2);
        eng_start = 1'b1; tick(1); eng_start = 1'b0;
        chk("R5 unit running", go, 1'b0);
        chk("R8 same-cycle hit no overrun", ovr, 1'b0);
        done_pulse(4'b0010);
        chk("R7 same-cycle hit kept", go, 1'b1);
        start_pulse(); done_pulse(4'b0010);
        evt_in[7] = 1'b0; tick(4);
        chk("R5 idle at end", go, 1'b0);

        finish_run();
    end
endmodule